// File: doc/BRIEF.md
# Graphics RAM Command Decoder and Bank Tracker

This block is the device-side command front end of a small synchronous graphics RAM with two internal banks. It samples the chip select, row strobe, column strobe, write enable, clock enable and the block-write select on every rising clock edge. It turns those pins into one command per cycle: activate, read, write, block write, precharge, auto refresh, mode load or no-operation. The 10-bit multiplexed address is split into a 9-bit row, an 8-bit column and a 1-bit bank field, depending on the command.

For each bank the block tracks whether a row is open and which row it is. It remembers whether the mode word has been loaded. A command that is not allowed in the current state is reported as illegal and has no effect. All results come out of registers one cycle after the edge that sampled the command. A storage array and a data path built next to this block act only on commands it reports as accepted.

Top module: `sgram_cmd_front`

## Requirements
- R1: A synchronous active-high reset closes both banks, clears every open row to 0, clears the mode-loaded flag and the mode word, and drives `cmd_valid`, `cmd_code`, all command fields and `cmd_illegal` to 0.
- R2: On an edge where `cke` is low, the sampled command is ignored. In the next cycle `cmd_valid` is 0, `cmd_code` is 0 (no-op), and the bank state and mode state are unchanged.
- R3: On an edge where `cke` is high and `cs_n` is high, the command is a no-op whatever the other strobes are. `cmd_valid` is 1, `cmd_code` is 0 and `cmd_illegal` is 0.
- R4: With `cs_n` low, {`ras_n`,`cas_n`,`we_n`} decodes as follows: 011 is activate (code 1), 101 is read (code 2), 100 is write (code 3, or block write code 4), 010 is precharge (code 5), 001 is auto refresh (code 6), 000 is mode load (code 7), and 110 or 111 is a no-op (code 0). Results appear one cycle after the sampling edge.
- R5: For activate, `cmd_bank`=addr[9] and `cmd_row`=addr[8:0]. For read, write and block write, `cmd_bank`=addr[9], `cmd_col`=addr[7:0] and `cmd_flag`=addr[8], which requests auto-precharge. For precharge, `cmd_bank`=addr[9] and `cmd_flag`=addr[8], which selects all banks. Fields that a command does not use are 0.
- R6: Until a mode load has been accepted, activate, read, write and block write are flagged illegal and change nothing.
- R7: An accepted activate opens the addressed bank and records its row. An activate to a bank that is already open is illegal and leaves the recorded row unchanged.
- R8: A read, write or block write to a closed bank is illegal and changes no bank state.
- R9: An accepted read, write or block write with auto-precharge closes its bank after the access, and the row of that bank reads 0.
- R10: A precharge with `cmd_flag`=0 closes only the addressed bank. With `cmd_flag`=1 it closes both banks. A precharge is always legal.
- R11: An auto refresh while any bank is open is illegal and has no effect. With all banks closed it is legal.
- R12: An accepted mode load stores addr[9:0] in `mode_word` and sets `mode_ready`. A mode load while any bank is open is illegal and leaves the mode state unchanged.
- R13: `blk_sel` high turns a write into a block write (code 4). It has no effect on any other command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low means the sampled command is ignored |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| blk_sel | input | 1 | Selects block write on a write command |
| addr | input | 10 | Multiplexed row/column/bank address |
| cmd_valid | output | 1 | A command was sampled with `cke` high |
| cmd_code | output | 3 | Decoded command code |
| cmd_bank | output | 1 | Bank field of the command |
| cmd_row | output | 9 | Row field (activate only) |
| cmd_col | output | 8 | Column field (accesses only) |
| cmd_flag | output | 1 | Auto-precharge on accesses; all-banks on precharge |
| cmd_illegal | output | 1 | Command rejected for the current state |
| bank_open | output | 2 | Open flag per bank, bit index = bank |
| open_rows | output | 18 | Open row per bank, bank b in bits [9b+8:9b] |
| mode_ready | output | 1 | A mode load has been accepted |
| mode_word | output | 10 | Last accepted mode word |

## Verification
The hardest states to reach from the pins are those with both banks open at the same moment after a mode load, because only in those states are refresh, mode load, all-bank precharge and auto-precharge accesses judged against real open rows. The bench first applies a mode load, then activates both banks, and then issues each of these commands in turn, reopening the banks between them. Both directed steps and a long run of random strobes are compared every clock against a behavioural model of the bank state.

// File: rtl/sgram_pkg.sv
package sgram_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ACT     = 3'd1,
    OP_READ    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_BLKWR   = 3'd4,
    OP_PRE     = 3'd5,
    OP_REFRESH = 3'd6,
    OP_MODE    = 3'd7
  } sg_op_e;

  function automatic logic is_access(input sg_op_e op);
    return (op == OP_READ) || (op == OP_WRITE) || (op == OP_BLKWR);
  endfunction
endpackage

// File: rtl/sgram_cmd_decode.sv
module sgram_cmd_decode
  import sgram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int ROW_W  = 9,
  parameter int COL_W  = 8,
  parameter int BANK_W = 1
) (
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              blk_sel,
  input  logic [ADDR_W-1:0] addr,
  output sg_op_e            op,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic              flag
);
  localparam int FLAG_POS = ADDR_W - BANK_W - 1;

  always_comb begin
    op   = OP_NOP;
    bank = '0;
    row  = '0;
    col  = '0;
    flag = 1'b0;
    if (cke && !cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011: begin
          op   = OP_ACT;
          bank = addr[ADDR_W-1 -: BANK_W];
          row  = addr[ROW_W-1:0];
        end
        3'b101, 3'b100: begin
          if (we_n)         op = OP_READ;
          else if (blk_sel) op = OP_BLKWR;
          else              op = OP_WRITE;
          bank = addr[ADDR_W-1 -: BANK_W];
          col  = addr[COL_W-1:0];
          flag = addr[FLAG_POS];
        end
        3'b010: begin
          op   = OP_PRE;
          bank = addr[ADDR_W-1 -: BANK_W];
          flag = addr[FLAG_POS];
        end
        3'b001:  op = OP_REFRESH;
        3'b000:  op = OP_MODE;
        default: op = OP_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sgram_cmd_gate.sv
module sgram_cmd_gate
  import sgram_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  sg_op_e               op,
  input  logic [BANK_W-1:0]    bank,
  input  logic                 flag,
  input  logic [NUM_BANKS-1:0] open_now,
  input  logic                 mode_ready,
  output logic                 illegal,
  output logic [NUM_BANKS-1:0] open_req,
  output logic [NUM_BANKS-1:0] close_req
);
  logic tgt_open;
  logic any_open;

  assign tgt_open = open_now[bank];
  assign any_open = |open_now;

  always_comb begin
    unique case (op)
      OP_ACT:                      illegal = !mode_ready || tgt_open;
      OP_READ, OP_WRITE, OP_BLKWR: illegal = !mode_ready || !tgt_open;
      OP_REFRESH, OP_MODE:         illegal = any_open;
      default:                     illegal = 1'b0;
    endcase
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_req
    logic hit;
    assign hit = (bank == BANK_W'(b));
    assign open_req[b]  = (op == OP_ACT) && !illegal && hit;
    assign close_req[b] = (is_access(op) && !illegal && flag && hit) ||
                          ((op == OP_PRE) && (flag || hit));
  end
endmodule

// File: rtl/sgram_bank_slot.sv
module sgram_bank_slot #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_req,
  input  logic             close_req,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      is_open <= 1'b0;
      row_q   <= '0;
    end else if (open_req) begin
      is_open <= 1'b1;
      row_q   <= row_in;
    end else if (close_req) begin
      is_open <= 1'b0;
      row_q   <= '0;
    end
  end
endmodule

// File: rtl/sgram_cmd_front.sv
module sgram_cmd_front
  import sgram_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int ROW_W     = 9,
  parameter int COL_W     = 8,
  parameter int NUM_BANKS = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic                       blk_sel,
  input  logic [ADDR_W-1:0]          addr,
  output logic                       cmd_valid,
  output logic [2:0]                 cmd_code,
  output logic [BANK_W-1:0]          cmd_bank,
  output logic [ROW_W-1:0]           cmd_row,
  output logic [COL_W-1:0]           cmd_col,
  output logic                       cmd_flag,
  output logic                       cmd_illegal,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic                       mode_ready,
  output logic [ADDR_W-1:0]          mode_word
);
  sg_op_e              d_op;
  logic [BANK_W-1:0]   d_bank;
  logic [ROW_W-1:0]    d_row;
  logic [COL_W-1:0]    d_col;
  logic                d_flag;
  logic                d_illegal;
  logic [NUM_BANKS-1:0] open_req;
  logic [NUM_BANKS-1:0] close_req;

  sgram_cmd_decode #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W)
  ) u_decode (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .blk_sel(blk_sel), .addr(addr),
    .op(d_op), .bank(d_bank), .row(d_row), .col(d_col), .flag(d_flag)
  );

  sgram_cmd_gate #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
  ) u_gate (
    .op(d_op), .bank(d_bank), .flag(d_flag), .open_now(bank_open),
    .mode_ready(mode_ready), .illegal(d_illegal),
    .open_req(open_req), .close_req(close_req)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sgram_bank_slot #(.ROW_W(ROW_W)) u_slot (
      .clk(clk), .rst(rst),
      .open_req(open_req[b]), .close_req(close_req[b]),
      .row_in(d_row),
      .is_open(bank_open[b]),
      .row_q(open_rows[b*ROW_W +: ROW_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_ready <= 1'b0;
      mode_word  <= '0;
    end else if (d_op == OP_MODE && !d_illegal) begin
      mode_ready <= 1'b1;
      mode_word  <= addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid   <= 1'b0;
      cmd_code    <= '0;
      cmd_bank    <= '0;
      cmd_row     <= '0;
      cmd_col     <= '0;
      cmd_flag    <= 1'b0;
      cmd_illegal <= 1'b0;
    end else begin
      cmd_valid   <= cke;
      cmd_code    <= d_op;
      cmd_bank    <= d_bank;
      cmd_row     <= d_row;
      cmd_col     <= d_col;
      cmd_flag    <= d_flag;
      cmd_illegal <= d_illegal;
    end
  end
endmodule

// File: rtl/sgram_cmd_front_chk.sv
module sgram_cmd_front_chk
  import sgram_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_BANKS = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cke,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [ADDR_W-1:0]    addr,
  input logic                 cmd_valid,
  input logic [2:0]           cmd_code,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic                 cmd_flag,
  input logic                 cmd_illegal,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic                 mode_ready,
  input logic [ADDR_W-1:0]    mode_word
);
  logic acc_code;
  assign acc_code = (cmd_code == OP_READ) || (cmd_code == OP_WRITE) ||
                    (cmd_code == OP_BLKWR);

  // R1
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (bank_open == '0 && !mode_ready && !cmd_valid && !cmd_illegal));

  // R2
  assert_cke_low_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    !cke |=> (!cmd_valid && $stable(bank_open) && $stable(mode_word) &&
              $stable(mode_ready)));

  // R3
  assert_deselect_nop_R3: assert property (@(posedge clk) disable iff (rst)
    (cke && cs_n) |=> (cmd_valid && cmd_code == OP_NOP && !cmd_illegal));

  // R6
  assert_no_access_before_mode_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !mode_ready && (acc_code || cmd_code == OP_ACT)) |-> cmd_illegal);

  // R7
  assert_activate_opens_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == OP_ACT && !cmd_illegal) |-> bank_open[cmd_bank]);

  // R8
  assert_closed_access_rejected_R8: assert property (@(posedge clk) disable iff (rst)
    (cke && !cs_n && ras_n && !cas_n && !bank_open[addr[ADDR_W-1 -: BANK_W]])
      |=> (cmd_illegal && $stable(bank_open)));

  // R9
  assert_autopre_closes_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && acc_code && cmd_flag && !cmd_illegal) |-> !bank_open[cmd_bank]);

  // R10
  assert_precharge_all_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == OP_PRE && cmd_flag) |-> (bank_open == '0 && !cmd_illegal));

  // R11
  assert_refresh_open_rejected_R11: assert property (@(posedge clk) disable iff (rst)
    (cke && !cs_n && !ras_n && !cas_n && we_n && (|bank_open))
      |=> (cmd_illegal && $stable(bank_open)));
endmodule

bind sgram_cmd_front sgram_cmd_front_chk #(
  .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)
) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .addr(addr), .cmd_valid(cmd_valid),
  .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_flag(cmd_flag),
  .cmd_illegal(cmd_illegal), .bank_open(bank_open),
  .mode_ready(mode_ready), .mode_word(mode_word)
);

// File: tb/sgram_cmd_front_test.sv
module sgram_cmd_front_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, blk_sel = 1'b0;
  logic [9:0] addr = '0;

  logic        cmd_valid, cmd_flag, cmd_illegal, mode_ready;
  logic [2:0]  cmd_code;
  logic [0:0]  cmd_bank;
  logic [8:0]  cmd_row;
  logic [7:0]  cmd_col;
  logic [1:0]  bank_open;
  logic [17:0] open_rows;
  logic [9:0]  mode_word;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  always #2 clk = ~clk;  // 250 MHz

  sgram_cmd_front uut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .blk_sel(blk_sel), .addr(addr),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_flag(cmd_flag),
    .cmd_illegal(cmd_illegal), .bank_open(bank_open), .open_rows(open_rows),
    .mode_ready(mode_ready), .mode_word(mode_word)
  );

  // behavioural reference state
  bit       m_open [2];
  int       m_row  [2];
  bit       m_ready;
  int       m_word;
  bit       e_valid, e_flag, e_ill;
  int       e_code, e_bank, e_row, e_col;

  function automatic logic [54:0] expected_vec();
    logic [17:0] rows;
    rows = {9'(m_row[1]), 9'(m_row[0])};
    return {e_valid, 3'(e_code), 1'(e_bank), 9'(e_row), 8'(e_col), e_flag, e_ill,
            m_open[1], m_open[0], rows, m_ready, 10'(m_word)};
  endfunction

  function automatic logic [54:0] actual_vec();
    return {cmd_valid, cmd_code, cmd_bank, cmd_row, cmd_col, cmd_flag, cmd_illegal,
            bank_open, open_rows, mode_ready, mode_word};
  endfunction

  task automatic compare(input string tag);
    vectors++;
    if (actual_vec() !== expected_vec()) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", tag, actual_vec(), expected_vec());
    end
  endtask

  task automatic model_reset();
    m_open = '{0, 0}; m_row = '{0, 0}; m_ready = 0; m_word = 0;
    e_valid = 0; e_code = 0; e_bank = 0; e_row = 0; e_col = 0; e_flag = 0; e_ill = 0;
  endtask

  task automatic model_cmd(input bit k, c, r, ca, w, bs, input int a);
    int b;
    bit acc;
    b = (a >> 9) & 1;
    e_valid = k; e_code = 0; e_bank = 0; e_row = 0; e_col = 0; e_flag = 0; e_ill = 0;
    if (!k || c) return;
    case ({r, ca, w})
      3'b011: begin e_code = 1; e_bank = b; e_row = a & 9'h1FF; end
      3'b101: begin e_code = 2; e_bank = b; e_col = a & 8'hFF; e_flag = a[8]; end
      3'b100: begin e_code = bs ? 4 : 3; e_bank = b; e_col = a & 8'hFF; e_flag = a[8]; end
      3'b010: begin e_code = 5; e_bank = b; e_flag = a[8]; end
      3'b001: e_code = 6;
      3'b000: e_code = 7;
      default: e_code = 0;
    endcase
    acc = (e_code >= 2 && e_code <= 4);
    if (e_code == 1) begin
      if (!m_ready || m_open[b]) e_ill = 1;
      else begin m_open[b] = 1; m_row[b] = e_row; end
    end else if (acc) begin
      if (!m_ready || !m_open[b]) e_ill = 1;
      else if (e_flag) begin m_open[b] = 0; m_row[b] = 0; end
    end else if (e_code == 5) begin
      for (int i = 0; i < 2; i++)
        if (e_flag || i == b) begin m_open[i] = 0; m_row[i] = 0; end
    end else if (e_code == 6) begin
      if (m_open[0] || m_open[1]) e_ill = 1;
    end else if (e_code == 7) begin
      if (m_open[0] || m_open[1]) e_ill = 1;
      else begin m_ready = 1; m_word = a & 10'h3FF; end
    end
  endtask

  // called at a negedge; drives, waits for the sampling edge, checks at next negedge
  task automatic step(input bit k, c, r, ca, w, bs, input int a, input string tag);
    cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; blk_sel = bs; addr = 10'(a);
    @(posedge clk);
    model_cmd(k, c, r, ca, w, bs, a);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
  endtask

  // command shorthands: k c r ca w
  task automatic act(input int a, input string t);   step(1,0,0,1,1,0,a,t); endtask
  task automatic rd(input int a, input string t);    step(1,0,1,0,1,0,a,t); endtask
  task automatic wr(input int a, input bit bs, input string t); step(1,0,1,0,0,bs,a,t); endtask
  task automatic pre(input int a, input string t);   step(1,0,0,1,0,0,a,t); endtask
  task automatic refr(input string t);               step(1,0,0,0,1,0,0,t); endtask
  task automatic mrs(input int a, input string t);   step(1,0,0,0,0,0,a,t); endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();                                  // R1
    act(10'h0A5, "R6");                          // activate before mode load
    rd(10'h012, "R6");
    wr(10'h212, 1, "R6");
    step(0,0,0,0,0,0, 10'h155, "R2");            // mode load with cke low
    step(1,1,0,0,0,0, 10'h155, "R3");            // deselected mode load
    step(1,1,0,1,1,0, 10'h0AA, "R3");
    mrs(10'h237, "R12");
    act(10'h1A5, "R5");                          // bank0 row 1A5
    act(10'h033, "R7");                          // bank0 already open
    rd(10'h244, "R8");                           // bank1 closed
    wr(10'h20F, 1, "R8");
    act(10'h2F0, "R7");                          // bank1 row 0F0
    refr("R11");
    mrs(10'h001, "R12");
    wr(10'h03C, 0, "R4");
    wr(10'h25A, 1, "R13");                       // block write bank1
    step(1,0,1,0,1,1, 10'h2C3, "R13");          // read with blk_sel high
    step(1,0,0,1,1,1, 10'h0FF, "R13");          // activate with blk_sel, bank0 open
    step(1,0,1,1,0,0, 10'h3FF, "R4");            // 110 decodes as no-op
    step(1,0,1,1,1,0, 10'h3FF, "R4");
    rd(10'h377, "R9");                           // bank1 read with auto-precharge
    rd(10'h277, "R8");                           // bank1 now closed
    step(0,0,0,1,0,0, 10'h100, "R2");            // precharge-all with cke low
    wr(10'h1C8, 0, "R9");                        // bank0 write auto-precharge
    act(10'h111, "R7");
    act(10'h322, "R7");
    pre(10'h000, "R10");                         // bank0 only
    pre(10'h000, "R10");                         // already closed, still legal
    act(10'h0EE, "R7");
    pre(10'h300, "R10");                         // all banks
    refr("R11");                                 // legal now
    mrs(10'h3C1, "R12");
    act(10'h0A5, "R5");
    do_reset();                                  // mid-run reset, R1
    act(10'h0A5, "R6");
    mrs(10'h010, "R12");
    for (int i = 0; i < 600; i++) begin
      int x;
      x = int'($urandom);
      step((x & 15) != 0, ((x >> 4) & 7) == 0, x[7], x[8], x[9], x[10],
           (x >> 11) & 10'h3FF, "R4");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule